// File: doc/BRIEF.md
# Dual-Bank Serial Field Delay Memory

This block is a serial-access field memory with two byte-wide banks. Each bank has its own write clock and its own write pointer, which steps through the banks in order. A single read clock and a single read pointer serve both banks at once, so one read produces a 16-bit word. The block has no full flag, no empty flag and no address inputs. The pointers move only when their port is clocked, and a pointer reset returns it to location zero. The delay between a stream going in and the same stream coming out is set by how far apart the write reset and the read reset are.

Each side has two kinds of gating. A write hold or a read hold freezes its pointer. A write mask or an output mask lets the pointer keep moving but suppresses the data. A masked write leaves the old contents in place, so a caller can overwrite selected regions, such as an inset picture. A masked read skips those words and drives zeros with the valid flag low. Because each bank has its own write clock, the two byte lanes can be filled by separate sources, for example the two halves of a split screen.

Top module: `dual_bank_field_delay`

## Requirements
- R1: On a write clock edge of a bank where its pointer reset is high, its write hold input is high and its write mask input is high, the input byte is stored at the current write address and the pointer advances by one.
- R2: On a write clock edge where the write hold input (`wa_go`/`wb_go`) is low and the reset is high, that bank's pointer keeps its value and nothing is stored.
- R3: On a write clock edge where the hold input is high and the write mask input (`wa_keep_n`/`wb_keep_n`) is low, the addressed location keeps its old contents and the pointer still advances.
- R4: A write clock edge with the active-low pointer reset low sets that bank's pointer to zero and stores nothing, whatever the hold and mask inputs are.
- R5: A read clock edge with `rd_zero_n` low sets the read pointer to zero and forces `rd_valid` to 0 and `rd_data` to zero, whatever `rd_go` is. The next read clock edge that reads presents word 0, with no extra latency.
- R6: On a read clock edge where `rd_go` is low, the read pointer, `rd_data` and `rd_valid` all hold, and `rd_show` is ignored.
- R7: On a read clock edge where `rd_go` is high and `rd_show` is low, `rd_data` becomes zero and `rd_valid` goes to 0, and the read pointer still advances, so that word is skipped.
- R8: The write pointers and the read pointer wrap from DEPTH-1 back to 0.
- R9: Each bank is written only on its own write clock. A read returns bank A in `rd_data[7:0]` and bank B in `rd_data[15:8]`, both taken from the same read address, with `rd_valid` set to 1 when `rd_show` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wa_clk | input | 1 | Bank A write clock |
| wa_zero_n | input | 1 | Bank A write pointer reset, synchronous, active low |
| wa_go | input | 1 | Bank A write hold; low freezes the pointer |
| wa_keep_n | input | 1 | Bank A write mask; low keeps the old contents while the pointer moves |
| wa_byte | input | 8 | Bank A write data |
| wb_clk | input | 1 | Bank B write clock |
| wb_zero_n | input | 1 | Bank B write pointer reset, synchronous, active low |
| wb_go | input | 1 | Bank B write hold |
| wb_keep_n | input | 1 | Bank B write mask |
| wb_byte | input | 8 | Bank B write data |
| rd_clk | input | 1 | Shared read clock |
| rd_zero_n | input | 1 | Read pointer reset, synchronous, active low |
| rd_go | input | 1 | Read hold; low freezes the pointer and the outputs |
| rd_show | input | 1 | Output mask; low drives zeros while the pointer moves |
| rd_data | output | 16 | Read word: bank B in the upper byte, bank A in the lower byte |
| rd_valid | output | 1 | High when rd_data carries a stored word |

## Verification
A write takes effect at the write clock edge that samples it. A read result appears one read clock edge after the inputs that request it. The register that follows that edge is the only register on the path. The bench therefore sets the inputs, waits for one edge of the relevant clock and samples 2 ns after it. It never compares across an edge of a different clock. Stored contents are compared only through later reads, which start after a read reset so the pointer position is known.

// File: rtl/fdm_pkg.sv
// Shared constants and types for the dual-bank field delay memory.
// Assumes exactly two byte lanes; widths derive from BYTE_W.
package fdm_pkg;
    localparam int NUM_BANKS = 2;
    localparam int BYTE_W    = 8;
    localparam int WORD_W    = NUM_BANKS * BYTE_W;
    typedef logic [BYTE_W-1:0] lane_t;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/fdm_ptr.sv
// Sequential address pointer with synchronous active-low reset to zero.
// Reset wins over advance; the pointer wraps from DEPTH-1 to 0.
// Assumes DEPTH >= 2 and AW wide enough to hold DEPTH-1.
module fdm_ptr #(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    // Step, wrap or clear the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (adv)
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
endmodule

// File: rtl/fdm_bank.sv
// One byte-wide storage bank: a dual-clock RAM with a write port on the
// bank's own clock and a registered read port on the shared read clock.
// Assumes callers never read and write one address in the same instant.
module fdm_bank #(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH),
    parameter int W     = 8
) (
    input  logic          wclk,
    input  logic          wr,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          rclk,
    input  logic          rd,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // Store one byte per enabled write edge.
    always_ff @(posedge wclk) begin
        if (wr)
            mem[waddr] <= wdata;
    end

    // Fetch one byte per enabled read edge; holds otherwise.
    always_ff @(posedge rclk) begin
        if (rd)
            rdata <= mem[raddr];
    end
endmodule

// File: rtl/fdm_rd_out.sv
// Output stage: tracks whether the last fetched word is shown and masks
// the RAM output to zero when it is not. Synchronous active-low reset.
// Assumes q is the registered RAM word fetched on the same read edges.
module fdm_rd_out #(
    parameter int WW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          show,
    input  logic [WW-1:0] q,
    output logic [WW-1:0] data,
    output logic          valid
);
    logic shown_q;

    // Remember the output mask for the word fetched on this edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shown_q <= 1'b0;
        else if (go)
            shown_q <= show;
    end

    // Drive zeros when the word is masked.
    always_comb begin
        valid = shown_q;
        data  = shown_q ? q : '0;
    end
endmodule

// File: rtl/dual_bank_field_delay.sv
// Two-bank serial field delay memory. Each bank has a write clock, a
// pointer reset, a hold input and a mask input. Both banks share one read
// pointer and read clock and form one 16-bit word. The pointers are moved
// only by clocking and reset, and nothing reports full or empty.
// Assumes DEPTH >= 2; all resets are synchronous to their own clock.
module dual_bank_field_delay
    import fdm_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic              wa_clk,
    input  logic              wa_zero_n,
    input  logic              wa_go,
    input  logic              wa_keep_n,
    input  logic [BYTE_W-1:0] wa_byte,
    input  logic              wb_clk,
    input  logic              wb_zero_n,
    input  logic              wb_go,
    input  logic              wb_keep_n,
    input  logic [BYTE_W-1:0] wb_byte,
    input  logic              rd_clk,
    input  logic              rd_zero_n,
    input  logic              rd_go,
    input  logic              rd_show,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic              w_clk   [NUM_BANKS];
    logic              w_rst_n [NUM_BANKS];
    logic              w_go    [NUM_BANKS];
    logic              w_keep  [NUM_BANKS];
    lane_t             w_byte  [NUM_BANKS];
    logic [AW-1:0]     wptr    [NUM_BANKS];
    logic [AW-1:0]     rptr;
    logic              rd_fetch;
    word_t             rd_word;

    // Gather the per-bank write pins into arrays for the generate loop.
    always_comb begin
        w_clk[0] = wa_clk;  w_rst_n[0] = wa_zero_n; w_go[0] = wa_go;
        w_keep[0] = wa_keep_n; w_byte[0] = wa_byte;
        w_clk[1] = wb_clk;  w_rst_n[1] = wb_zero_n; w_go[1] = wb_go;
        w_keep[1] = wb_keep_n; w_byte[1] = wb_byte;
    end

    // A read fetch happens on read edges that are neither held nor reset.
    assign rd_fetch = rd_go & rd_zero_n;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic wr_en;
        assign wr_en = w_rst_n[b] & w_go[b] & w_keep[b];

        fdm_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wptr (
            .clk  (w_clk[b]),
            .rst_n(w_rst_n[b]),
            .adv  (w_go[b]),
            .ptr  (wptr[b])
        );

        fdm_bank #(.DEPTH(DEPTH), .AW(AW), .W(BYTE_W)) u_ram (
            .wclk (w_clk[b]),
            .wr   (wr_en),
            .waddr(wptr[b]),
            .wdata(w_byte[b]),
            .rclk (rd_clk),
            .rd   (rd_fetch),
            .raddr(rptr),
            .rdata(rd_word[b*BYTE_W +: BYTE_W])
        );
    end

    fdm_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rptr (
        .clk  (rd_clk),
        .rst_n(rd_zero_n),
        .adv  (rd_go),
        .ptr  (rptr)
    );

    fdm_rd_out #(.WW(WORD_W)) u_out (
        .clk  (rd_clk),
        .rst_n(rd_zero_n),
        .go   (rd_go),
        .show (rd_show),
        .q    (rd_word),
        .data (rd_data),
        .valid(rd_valid)
    );
endmodule

// File: rtl/fdm_checker.sv
// Property checker for the dual-bank field delay memory, attached by bind.
// Checks start once each port has seen its pointer reset, because a pointer
// is undefined before then.
module fdm_checker #(
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input logic          rd_clk,
    input logic          rd_zero_n,
    input logic          rd_go,
    input logic          rd_show,
    input logic [15:0]   rd_data,
    input logic          rd_valid,
    input logic [AW-1:0] rptr,
    input logic          wa_clk,
    input logic          wa_zero_n,
    input logic          wa_go,
    input logic [AW-1:0] wptr_a
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    logic rd_armed = 1'b0;
    logic wa_armed = 1'b0;

    // Arm the read checks after the first read reset.
    always_ff @(posedge rd_clk) if (!rd_zero_n) rd_armed <= 1'b1;
    // Arm the write checks after the first bank A reset.
    always_ff @(posedge wa_clk) if (!wa_zero_n) wa_armed <= 1'b1;

    AST_RD_ZERO: assert property (@(posedge rd_clk) disable iff (!rd_armed)
        !rd_zero_n |=> (rptr == '0) && !rd_valid && (rd_data == '0)); // R5
    AST_RD_HOLD: assert property (@(posedge rd_clk) disable iff (!rd_armed)
        rd_zero_n && !rd_go |=> $stable(rptr) && $stable(rd_data) && $stable(rd_valid)); // R6
    AST_OE_MASK: assert property (@(posedge rd_clk) disable iff (!rd_armed)
        rd_zero_n && rd_go && !rd_show |=> !rd_valid && (rd_data == '0) && !$stable(rptr)); // R7
    AST_RD_WRAP: assert property (@(posedge rd_clk) disable iff (!rd_armed)
        rd_zero_n && rd_go && (rptr == LAST) |=> (rptr == '0)); // R8
    AST_WA_HOLD: assert property (@(posedge wa_clk) disable iff (!wa_armed)
        wa_zero_n && !wa_go |=> $stable(wptr_a)); // R2
    AST_WA_ZERO: assert property (@(posedge wa_clk) disable iff (!wa_armed)
        !wa_zero_n |=> (wptr_a == '0)); // R4
endmodule

bind dual_bank_field_delay fdm_checker #(.DEPTH(DEPTH), .AW(AW)) u_chk (
    .rd_clk   (rd_clk),
    .rd_zero_n(rd_zero_n),
    .rd_go    (rd_go),
    .rd_show  (rd_show),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .rptr     (rptr),
    .wa_clk   (wa_clk),
    .wa_zero_n(wa_zero_n),
    .wa_go    (wa_go),
    .wptr_a   (wptr[0])
);

// File: tb/sim_dual_bank_field_delay.sv
module sim_dual_bank_field_delay;
    localparam int DEPTH = 16;

    logic wa_clk = 0, wb_clk = 0, rd_clk = 0;
    logic wa_zero_n = 0, wa_go = 0, wa_keep_n = 0;
    logic wb_zero_n = 0, wb_go = 0, wb_keep_n = 0;
    logic [7:0] wa_byte = '0, wb_byte = '0;
    logic rd_zero_n = 0, rd_go = 0, rd_show = 0;
    logic [15:0] rd_data;
    logic rd_valid;
    int n_chk = 0, n_bad = 0;

    always #4 rd_clk = ~rd_clk;
    always #4 wa_clk = ~wa_clk;
    always #5 wb_clk = ~wb_clk;

    dual_bank_field_delay #(.DEPTH(DEPTH)) u0 (.*);

    // {rd_go, rd_show, exp_valid, exp_data}
    localparam logic [18:0] VEC [7] = '{
        {1'b1, 1'b1, 1'b1, 16'h8010},
        {1'b1, 1'b1, 1'b1, 16'h8111},
        {1'b0, 1'b1, 1'b1, 16'h8111},
        {1'b1, 1'b0, 1'b0, 16'h0000},
        {1'b1, 1'b1, 1'b1, 16'h8313},
        {1'b0, 1'b0, 1'b1, 16'h8313},
        {1'b1, 1'b1, 1'b1, 16'h8414}
    };

    task automatic check(input string tag, input logic [16:0] got, input logic [16:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got valid=%b data=%h, expected valid=%b data=%h",
                     tag, got[16], got[15:0], exp[16], exp[15:0]);
        end
    endtask

    task automatic wr_a(input logic z, input logic g, input logic k, input logic [7:0] d);
        wa_zero_n = z; wa_go = g; wa_keep_n = k; wa_byte = d;
        @(posedge wa_clk); #2;
        wa_go = 0;
    endtask

    task automatic wr_b(input logic z, input logic g, input logic k, input logic [7:0] d);
        wb_zero_n = z; wb_go = g; wb_keep_n = k; wb_byte = d;
        @(posedge wb_clk); #2;
        wb_go = 0;
    endtask

    task automatic rd(input logic z, input logic g, input logic s);
        rd_zero_n = z; rd_go = g; rd_show = s;
        @(posedge rd_clk); #2;
    endtask

    task automatic rd_chk(input string tag, input logic [15:0] exp);
        rd(1, 1, 1);
        check(tag, {rd_valid, rd_data}, {1'b1, exp});
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge rd_clk);
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // Reset all pointers (R4, R5)
        wr_a(0, 1, 1, 8'hEE);
        wr_b(0, 1, 1, 8'hEE);
        rd(0, 1, 1);
        check("R5 reset state", {rd_valid, rd_data}, 17'h0);

        // Fill: each bank on its own clock (R1, R9)
        for (int i = 0; i < DEPTH; i++) wr_a(1, 1, 1, 8'h10 + 8'(i));
        for (int i = 0; i < DEPTH; i++) wr_b(1, 1, 1, 8'h80 + 8'(i));

        // Vector table from read pointer zero (R1 R5 R6 R7 R9)
        rd(0, 0, 0);
        for (int v = 0; v < 7; v++) begin
            rd(1, VEC[v][18], VEC[v][17]);
            check($sformatf("R6/R7/R9 vector %0d", v), {rd_valid, rd_data}, VEC[v][16:0]);
        end

        // R2: hold freezes the pointer and stores nothing
        wr_a(0, 0, 0, 8'h00);
        wr_a(1, 1, 1, 8'hA0);
        wr_a(1, 1, 1, 8'hA1);
        wr_a(1, 0, 1, 8'h55);
        wr_a(1, 0, 1, 8'h55);
        wr_a(1, 1, 1, 8'hC2);
        // R3: the mask keeps old contents while the pointer advances
        wr_b(0, 0, 0, 8'h00);
        wr_b(1, 1, 0, 8'hFF);
        wr_b(1, 1, 1, 8'hB1);
        // R4: reset beats the enables; EE must not land at address 3
        wr_a(0, 1, 1, 8'hEE);
        wr_a(1, 1, 1, 8'hD0);

        rd(0, 1, 1);
        rd_chk("R4 reset write to addr0", 16'h80D0);
        rd_chk("R3 masked byte kept", 16'hB1A1);
        rd_chk("R2 hold then write", 16'h82C2);
        rd_chk("R2/R4 untouched addr3", 16'h8313);

        // R8: wrap of the write and read pointers
        wr_a(0, 0, 0, 8'h00);
        for (int i = 0; i <= DEPTH; i++) wr_a(1, 1, 1, 8'h40 + 8'(i));
        rd(0, 0, 0);
        for (int i = 0; i <= DEPTH; i++) begin
            logic [15:0] e;
            e = (i == 0 || i == DEPTH) ? 16'h8050 :
                (i == 1) ? 16'hB141 : {8'h80 + 8'(i), 8'h40 + 8'(i)};
            rd_chk($sformatf("R8 wrap word %0d", i), e);
        end

        // R5: read reset wins over rd_go, then word 0 follows at once
        rd_chk("R5 mid-stream", 16'hB141);
        rd(0, 1, 1);
        check("R5 reset priority", {rd_valid, rd_data}, 17'h0);
        rd_chk("R5 first word after reset", 16'h8050);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule